// File: doc/BRIEF.md
# Single-Level I/O Address Translation Walker

This block turns a 32-bit device address into a physical address by reading one page-table entry from memory. A device presents its address and a read/write flag on a valid/ready request channel. The block removes the translation-window bits from the address. It forms the entry address from the table base, issues one read on its memory port, and waits for the data. It then returns the physical address, the entry's permission bits and two fault flags on a valid/ready response channel.

Only one walk is in flight at a time. The table base, the window start and the global translation enable come from an external register block and are sampled when a request is accepted. With translation off, the device address passes straight through and no memory read is made.

Top module: `dva_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_req` is 0.
- R2: `req_ready` is low from the cycle after a request is accepted until the cycle after the response handshake completes. It is high in that following cycle.
- R3: The masked address is the request address with every bit cleared that is set in `win_start`. The entry read address is `(tbl_base << 4) + ((masked >> 10) & ~3)`. That is one 4-byte entry per 4 KB page.
- R4: For a valid entry, `rsp_paddr = ((entry & 32'h07ffff00) << 4) + (masked & 32'hfff)`. The entry's page number sits in bits 26..8, and the 12 low address bits pass through as the page offset.
- R5: For a valid entry, the response reports entry bit 2 on `rsp_writable`, bit 7 on `rsp_cacheable` and bit 0 on `rsp_waz`.
- R6: An entry with bit 1 (valid) clear gives `rsp_fault` = 1, `rsp_paddr` = 0, `rsp_prot` = 0 and all three permission outputs 0.
- R7: A write request (`req_write` = 1) to a valid entry with bit 2 clear gives `rsp_prot` = 1. A read request to the same entry gives `rsp_prot` = 0.
- R8: If `xlat_en` is 0 when a request is accepted, the response appears the next cycle. It has `rsp_paddr` equal to the request address, all flags and permission bits 0, and no memory read is issued.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response holds all its fields unchanged.
- R10: `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_valid` is seen. A `mem_rd_valid` pulse while no read is pending has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable, sampled at request acceptance |
| tbl_base | input | 32 | Page-table base, shifted left by 4 to form a byte address |
| win_start | input | 32 | Start of the translation window, its set bits are stripped from the address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_dva | input | 32 | Device address to translate |
| req_write | input | 1 | Request is a write |
| mem_rd_req | output | 1 | Entry read pending |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_data | input | 32 | Entry word |
| mem_rd_valid | input | 1 | Entry word is present on `mem_rd_data` |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Entry was not valid |
| rsp_prot | output | 1 | Write to a non-writable page |
| rsp_writable | output | 1 | Entry writable bit |
| rsp_cacheable | output | 1 | Entry cacheable bit |
| rsp_waz | output | 1 | Entry write-as-zero bit |

## Verification
A wrong walk state shows up at the handshake outputs in the very next cycle. A stuck or skipped state leaves `req_ready`, `mem_rd_req` or `rsp_valid` at a level the per-cycle reference model does not expect. A wrong latch of the address or flag shows up either on `mem_rd_addr` while the read is pending or on `rsp_paddr`, `rsp_prot` and the permission bits in the first response cycle. The bench stalls the response and varies the memory latency, so that held-value and late-data errors also surface within a walk.

// File: rtl/dva_walker.sv
module dva_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xlat_en,
  input  logic [31:0] tbl_base,
  input  logic [31:0] win_start,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_dva,
  input  logic        req_write,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic [31:0] mem_rd_data,
  input  logic        mem_rd_valid,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        rsp_prot,
  output logic        rsp_writable,
  output logic        rsp_cacheable,
  output logic        rsp_waz
);
  localparam int OFS_W   = 12;
  localparam int BIT_WAZ = 0;
  localparam int BIT_VAL = 1;
  localparam int BIT_WR  = 2;
  localparam int BIT_CCH = 7;
  localparam int PN_LO   = 8;
  localparam int PN_HI   = 26;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RESP} st_t;
  st_t st;

  logic [OFS_W-1:0] ofs_q;
  logic             wr_q;

  wire        req_fire = req_valid && req_ready;
  wire [31:0] masked   = req_dva & ~win_start;
  wire [31:0] ent_addr = {tbl_base[27:0], 4'b0000} + {10'b0, masked[31:OFS_W], 2'b00};
  wire        e_valid  = mem_rd_data[BIT_VAL];
  wire        e_wr     = mem_rd_data[BIT_WR];

  assign req_ready  = (st == S_IDLE);
  assign mem_rd_req = (st == S_FETCH);
  assign rsp_valid  = (st == S_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      ofs_q         <= '0;
      wr_q          <= 1'b0;
      mem_rd_addr   <= '0;
      rsp_paddr     <= '0;
      rsp_fault     <= 1'b0;
      rsp_prot      <= 1'b0;
      rsp_writable  <= 1'b0;
      rsp_cacheable <= 1'b0;
      rsp_waz       <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (req_fire) begin
          if (!xlat_en) begin
            rsp_paddr     <= req_dva;
            rsp_fault     <= 1'b0;
            rsp_prot      <= 1'b0;
            rsp_writable  <= 1'b0;
            rsp_cacheable <= 1'b0;
            rsp_waz       <= 1'b0;
            st            <= S_RESP;
          end else begin
            mem_rd_addr <= ent_addr;
            ofs_q       <= masked[OFS_W-1:0];
            wr_q        <= req_write;
            st          <= S_FETCH;
          end
        end
        S_FETCH: if (mem_rd_valid) begin
          if (!e_valid) begin
            rsp_paddr     <= '0;
            rsp_fault     <= 1'b1;
            rsp_prot      <= 1'b0;
            rsp_writable  <= 1'b0;
            rsp_cacheable <= 1'b0;
            rsp_waz       <= 1'b0;
          end else begin
            rsp_paddr     <= {1'b0, mem_rd_data[PN_HI:PN_LO], ofs_q};
            rsp_fault     <= 1'b0;
            rsp_prot      <= wr_q && !e_wr;
            rsp_writable  <= e_wr;
            rsp_cacheable <= mem_rd_data[BIT_CCH];
            rsp_waz       <= mem_rd_data[BIT_WAZ];
          end
          st <= S_RESP;
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dva_walker_chk.sv
module dva_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xlat_en,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_dva,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic        rsp_fault,
  input logic        rsp_prot,
  input logic        rsp_writable
);
  // R2
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2
  release_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready);
  // R10
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                   && $stable(rsp_prot) && $stable(rsp_writable)));
  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xlat_en) |=> (rsp_valid && !mem_rd_req && rsp_paddr == $past(req_dva)));
  // R6
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0 && !rsp_prot));
endmodule

bind dva_walker dva_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .req_valid(req_valid),
  .req_ready(req_ready), .req_dva(req_dva), .mem_rd_req(mem_rd_req),
  .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .rsp_prot(rsp_prot), .rsp_writable(rsp_writable)
);

// File: tb/dva_walker_bench.sv
module dva_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xlat_en = 1'b1;
  logic [31:0] tbl_base = '0, win_start = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_dva = '0;
  logic req_ready, mem_rd_req, rsp_valid;
  logic [31:0] mem_rd_addr, rsp_paddr;
  logic [31:0] mem_rd_data = '0;
  logic mem_rd_valid = 1'b0, rsp_ready = 1'b0;
  logic rsp_fault, rsp_prot, rsp_writable, rsp_cacheable, rsp_waz;

  always #(CLK_PERIOD/2) clk = ~clk;

  dva_walker u_dva_walker (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] tbl [int unsigned];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // behavioural reference: 0 idle, 1 fetching, 2 responding
  int m_st = 0;
  logic [31:0] m_addr, m_masked, m_paddr;
  bit m_wr, m_fault, m_prot, m_w, m_c, m_z;
  string m_tag = "R4";

  always @(posedge clk) begin
    if (!rst_n) m_st = 0;
    else begin
      case (m_st)
        0: if (req_valid) begin
          m_masked = req_dva & ~win_start;
          if (!xlat_en) begin
            m_paddr = req_dva; m_fault = 0; m_prot = 0; m_w = 0; m_c = 0; m_z = 0;
            m_tag = "R8"; m_st = 2;
          end else begin
            m_addr = (tbl_base << 4) + ((m_masked >> 10) & ~32'd3);
            m_wr = req_write; m_st = 1;
          end
        end
        1: if (mem_rd_valid) begin
          if (!mem_rd_data[1]) begin
            m_paddr = 0; m_fault = 1; m_prot = 0; m_w = 0; m_c = 0; m_z = 0; m_tag = "R6";
          end else begin
            m_paddr = ((mem_rd_data & 32'h07ffff00) << 4) + (m_masked & 32'hfff);
            m_fault = 0; m_w = mem_rd_data[2]; m_c = mem_rd_data[7]; m_z = mem_rd_data[0];
            m_prot = m_wr && !m_w; m_tag = "R4";
          end
          m_st = 2;
        end
        default: if (rsp_ready) m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "req_ready", req_ready, m_st == 0);
      chk("R10", "mem_rd_req", mem_rd_req, m_st == 1);
      chk("R9", "rsp_valid", rsp_valid, m_st == 2);
      if (m_st == 1) chk("R3", "mem_rd_addr", mem_rd_addr, m_addr);
      if (m_st == 2) begin
        chk(m_tag, "rsp_paddr", rsp_paddr, m_paddr);
        chk("R6", "rsp_fault", rsp_fault, m_fault);
        chk("R7", "rsp_prot", rsp_prot, m_prot);
        chk("R5", "perm bits", {rsp_writable, rsp_cacheable, rsp_waz}, {m_w, m_c, m_z});
      end
    end
  end

  // memory responder with rotating latency, plus response back-pressure
  int cd = -1, lat = 0, rr = 0;
  bit spur = 0;
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (spur) begin
      mem_rd_valid = 1'b1; mem_rd_data = 32'hffff_ffff; spur = 0;
    end else if (mem_rd_req) begin
      if (cd < 0) cd = lat;
      if (cd == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data = tbl.exists(mem_rd_addr) ? tbl[mem_rd_addr] : 32'h0;
        cd = -1; lat = (lat + 1) % 4;
      end else cd--;
    end
    rr++;
    rsp_ready = (rr % 3) != 2;
  end

  task automatic do_req(input logic [31:0] dva, input bit wr);
    @(negedge clk);
    req_valid = 1'b1; req_dva = dva; req_write = wr;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    tbl[32'h0100_0048] = 32'h0123_4586;
    tbl[32'h0100_000c] = 32'h00ab_cd03;
    tbl[32'h0100_1ffc] = 32'h0000_0004;
    tbl[32'h0100_0000] = 32'h07ff_ff02;
    tbl_base = 32'h0010_0000;
    win_start = 32'hff00_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "mem_rd_req", mem_rd_req, 0);
    do_req(32'hff01_2345, 0);   // R4 R5 valid, writable, cacheable
    do_req(32'hff01_2345, 1);   // R7 write allowed
    do_req(32'hff00_3abc, 1);   // R7 protection fault
    do_req(32'hff00_3abc, 0);   // R7 read allowed, R5 waz
    do_req(32'hff7f_f001, 0);   // R6 invalid entry
    @(negedge clk); spur = 1;   // R10 stray data while idle
    repeat (3) @(negedge clk);
    win_start = 32'h8000_0000;
    do_req(32'h8000_0123, 1);   // R3 wide window
    xlat_en = 1'b0;
    do_req(32'h1234_5678, 1);   // R8 bypass
    do_req(32'hff00_3abc, 0);   // R8 bypass ignores table
    xlat_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i % 2 == 0) tbl[32'h0100_0000 + i * 4] = {5'b0, 19'(i * 32'h111), 8'h82 | 8'(i & 5)};
      do_req(32'h8000_0000 | (i << 12) | (i * 4), i % 3 == 0);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule